// File: doc/BRIEF.md
# Triggered byte serial transmitter

This block turns a single-cycle trigger pulse into one asynchronous serial character on a single output line. When the trigger arrives, the 8-bit data word is captured together with its framing bits. The frame is then shifted out one bit at a time, each bit held for a fixed number of clock cycles. The default of 868 cycles at a 100 MHz clock gives a rate close to 115,200 baud.

A typical use is to send one character per button press. An edge detector after a debouncer supplies the trigger, and a set of switches supplies the byte. Any trigger that arrives while a character is still on the line is dropped.

Top module: `byte_serial_tx`

## Requirements
- R1: While no frame is being sent, and after reset, the line `txd` is high (1).
- R2: A frame is 10 bits: a start bit at 0, then data bits 0 through 7 (least significant first), then a stop bit at 1. There is no parity bit.
- R3: Each bit is held for exactly BIT_CYCLES clock cycles (default 868).
- R4: The data word is sampled in the cycle in which `trig` is high. The start bit appears on `txd` in the following cycle. Later changes to `din` do not affect the frame.
- R5: A `trig` that arrives while a frame is in progress is ignored, and the frame on the line continues unchanged.
- R6: A new frame can start only after the stop bit has been held for its full BIT_CYCLES. A trigger in the first idle cycle after that starts the next frame at once.
- R7: A synchronous reset `rst` forces `txd` high and returns the block to idle, abandoning any frame in progress.
- R8: For the byte 8'b1010_1010, the line carries 0,0,1,0,1,0,1,0,1,1 in time order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input | 1 | System clock |
| rst  | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Single-cycle send request |
| din  | input | 8 | Byte to send, sampled with `trig` |
| txd  | output | 1 | Serial data line, idle high |

## Verification
A wrong bit counter shows up as a frame that is too short or too long. The line returns high early, or the next frame starts late, within one bit period of the error. A wrong cycle divider stretches or shrinks every bit, so sampling at mid-bit reads the wrong data within the first few bits. A wrong shift direction or wrong frame load shows as wrong data bits when the rebuilt byte is compared with the byte sent, after at most ten bit periods. A busy flag that clears too early lets a trigger during a frame corrupt that frame.

// File: rtl/byte_serial_tx_pkg.sv
package byte_serial_tx_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 2;

  function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_W-1:0] b);
    return {1'b1, b, 1'b0};
  endfunction
endpackage

// File: rtl/bit_timer.sv
module bit_timer #(
  parameter int BIT_CYCLES = 868
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (rst) cnt <= LAST);
  assert_idle_clear_R3: assert property (@(posedge clk) disable iff (rst) !run |=> cnt == '0);
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import byte_serial_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              shift,
  output logic              line
);
  logic [FRAME_W-1:0] sreg;

  assign line = sreg[0];

  always_ff @(posedge clk) begin
    if (rst)        sreg <= '1;
    else if (load)  sreg <= build_frame(byte_in);
    else if (shift) sreg <= {1'b1, sreg[FRAME_W-1:1]};
  end

  assert_start_low_R2: assert property (@(posedge clk) disable iff (rst) load |=> !line);
endmodule

// File: rtl/byte_serial_tx.sv
module byte_serial_tx
  import byte_serial_tx_pkg::*;
#(
  parameter int BIT_CYCLES = 868
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       trig,
  input  logic [7:0] din,
  output logic       txd
);
  localparam int BW = $clog2(FRAME_W + 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

  logic          busy;
  logic [BW-1:0] bit_idx;
  logic          bit_tick;
  logic          start_evt;
  logic          frame_done;

  assign start_evt  = trig && !busy;
  assign frame_done = bit_tick && (bit_idx == LAST_BIT);

  bit_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .tick (bit_tick)
  );

  frame_shifter u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (start_evt),
    .byte_in (din),
    .shift   (bit_tick),
    .line    (txd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      bit_idx <= '0;
    end else if (start_evt) begin
      busy    <= 1'b1;
      bit_idx <= '0;
    end else if (frame_done) begin
      busy    <= 1'b0;
      bit_idx <= '0;
    end else if (bit_tick) begin
      bit_idx <= bit_idx + 1'b1;
    end
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst) !busy |-> txd);
  assert_stop_high_R2: assert property (@(posedge clk) disable iff (rst)
    busy && bit_idx == LAST_BIT |-> txd);
  assert_busy_ignore_R5: assert property (@(posedge clk) disable iff (rst)
    busy && trig && !frame_done |=> busy);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst) frame_done |=> !busy);
  assert_reset_R7: assert property (@(posedge clk) rst |=> txd && !busy);
endmodule

// File: tb/byte_serial_tx_tb.sv
module byte_serial_tx_tb;
  localparam int BC = 8;

  logic clk = 0, rst = 1, trig = 0;
  logic [7:0] din = 0;
  logic txd;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  byte_serial_tx #(.BIT_CYCLES(BC)) u_dut (
    .clk(clk), .rst(rst), .trig(trig), .din(din), .txd(txd)
  );

  function automatic logic frame_bit(input logic [7:0] b, input int i);
    if (i == 0) return 1'b0;
    if (i == 9) return 1'b1;
    return b[i-1];
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse(input logic [7:0] b);
    @(negedge clk); din = b; trig = 1;
    @(negedge clk); trig = 0; din = ~b;
  endtask

  // after pulse returns we are one negedge into bit 0 (cycle 0 of start bit)
  task automatic check_frame(input logic [7:0] b, input string req);
    for (int i = 0; i < 10; i++) begin
      for (int c = 0; c < BC; c++) begin
        if (c == 0 || c == BC/2 || c == BC-1)
          chk(req, txd, frame_bit(b, i));
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7", txd, 1'b1);
    rst = 0;
    repeat (5) @(negedge clk);
    chk("R1", txd, 1'b1);

    // R8 fixed pattern
    pulse(8'hAA);
    check_frame(8'hAA, "R8");
    chk("R1", txd, 1'b1);

    // R2/R3/R4 sweep over all bytes, back-to-back (R6)
    for (int v = 0; v < 256; v++) begin
      @(negedge clk); din = 8'(v); trig = 1;
      @(negedge clk); trig = 0; din = ~8'(v);
      check_frame(8'(v), "R2_R3_R4_R6");
      // now in first idle cycle: R6 line is high
      chk("R6", txd, 1'b1);
      if (v % 64 == 0) @(negedge clk);
    end

    // R5: triggers during a frame ignored
    pulse(8'h3C);
    for (int i = 0; i < 10; i++) begin
      for (int c = 0; c < BC; c++) begin
        if (c == BC/2) begin
          chk("R5", txd, frame_bit(8'h3C, i));
          trig = 1; din = 8'h00;
        end else trig = 0;
        @(negedge clk);
      end
    end
    trig = 0;
    chk("R5", txd, 1'b1);
    repeat (3 * BC) @(negedge clk);
    chk("R5", txd, 1'b1);

    // R7: reset mid-frame
    pulse(8'h00);
    repeat (2 * BC) @(negedge clk);
    chk("R7", txd, 1'b0);
    rst = 1; @(negedge clk); rst = 0;
    chk("R7", txd, 1'b1);
    repeat (12 * BC) @(negedge clk);
    chk("R7", txd, 1'b1);
    pulse(8'h5A);
    check_frame(8'h5A, "R7");

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule